// File: doc/BRIEF.md
# Sample-Queued Pulse Width Modulator

This block produces a single pulse-width-modulated output whose duty values arrive through a short queue. Software programs a divide ratio, a counter clock source, a period length and an output polarity in a control word. It then writes duty values into a sample register. Each write joins a four-deep queue, and the generator takes one value from that queue at the start of every output period. Software can therefore stage several duty steps ahead of time, and each step lasts exactly one period.

The counter clock is one of two tick-enable inputs. Both are sampled in the single system clock domain. The selected tick stream is divided by a programmable ratio. The period counter then steps from zero up to the programmed period plus one, so one period lasts the programmed value plus two prescaled ticks. A status word reports how full the queue is, together with a sticky flag that records a lost write. A software reset bit clears every register, the queue and the counter a few cycles after it is written, and it reads back as set until the clear has happened.

Top module: `pwm_fifo_gen`

## Requirements
- R1: The registers are at byte offsets 0x00 (control), 0x04 (status), 0x0C (sample) and 0x10 (period). All of them read 0 after reset. The control fields are:
  - bit 0: run enable
  - bit 3: software reset
  - bits 15:4: divide ratio minus one
  - bits 17:16: clock source
  - bit 18: output inversion
  - bits 24:22: three plain read/write low-power enables
  
  The period register keeps only bits 15:0. The sample register reads back the compare value currently in use.
- R2: With a divide field N and a period value P, one output period lasts (P+2)*(N+1) cycles of the selected tick.
- R3: Before inversion, the output is high from the start of each period while the count is below the compare value S, and low for the rest of it. The high time is therefore min(S, P+2)*(N+1) ticks.
- R4: Queued samples are used in the order they were written, one per period. When the queue is empty, the current compare value is kept.
- R5: Status bits 2:0 hold the number of queued samples, from 0 to 4. A value of 4 means the queue is full.
- R6: A sample write to a full queue is discarded and sets status bit 4. That bit stays set until software writes a 1 to it.
- R7: When control bit 18 is 1, the output is the complement of the uninverted waveform.
- R8: While bit 0 is 0, the counter is held at zero and the output is constant at the value of bit 18.
- R9: Writing 1 to bit 3 starts a software reset. Bit 3 reads 1 for at least one and at most 8 cycles. After that, all registers, the queue, the compare value and the output are zero.
- R10: Clock source 01 counts on tick_a and source 10 counts on tick_b. Sources 00 and 11 stop the counter.
- R11: A write that changes bit 0 from 0 to 1 starts a period on the next cycle, and that period uses a sample taken from the queue.
- R12: A sample write that arrives in the same cycle as a period rollover, while the queue is full, is accepted and does not set the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| tick_a | input | 1 | Counter tick enable for clock source 01 |
| tick_b | input | 1 | Counter tick enable for clock source 10 |
| pwm_out | output | 1 | Modulated output |

## Verification
Two events can coincide in one cycle: a period rollover that takes a sample from the queue, and a bus write that pushes a new sample into it. The bench fills the queue and enables the generator with a period of four ticks. It then times a sample write so that it lands exactly on the first rollover edge. The result is judged through the status word: the level must still read 4 and the overflow flag must stay clear. A checker property watches the same coincidence whenever it happens during the other tests.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
package pwm_pkg;
  // register byte offsets
  localparam int OFF_CTRL = 'h00;
  localparam int OFF_STAT = 'h04;
  localparam int OFF_SAMP = 'h0C;
  localparam int OFF_PER  = 'h10;

  // control word bit positions
  localparam int B_RUN    = 0;
  localparam int B_SRST   = 3;
  localparam int B_DIV_LO = 4;
  localparam int B_SRC_LO = 16;
  localparam int B_INV    = 18;
  localparam int B_LP_LO  = 22;

  // status word bit positions
  localparam int B_OVF    = 4;

  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_A    = 2'b01,
    SRC_B    = 2'b10,
    SRC_OFF  = 2'b11
  } src_sel_e;
endpackage

// File: rtl/pwm_sample_fifo.sv
`timescale 1ns/1ps
module pwm_sample_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [LW-1:0] level,
  output logic          has_data,
  output logic          push_ok
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          pop_ok;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign has_data = (level != '0);
  assign pop_ok   = pop && has_data;
  // a pop in the same cycle frees a slot for the push
  assign push_ok  = push && ((level != FULL_LVL) || pop_ok);
  assign head     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok && !clear) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/pwm_prescaler.sv
`timescale 1ns/1ps
module pwm_prescaler #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic             src_tick,
  input  logic [DIV_W-1:0] div_m1,
  output logic             tick
);
  logic [DIV_W-1:0] pcnt_q;

  // >= keeps the divider bounded if the ratio shrinks mid-count
  function automatic logic at_limit(input logic [DIV_W-1:0] c,
                                    input logic [DIV_W-1:0] lim);
    return c >= lim;
  endfunction

  assign tick = run && !restart && src_tick && at_limit(pcnt_q, div_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pcnt_q <= '0;
    else if (restart || !run)   pcnt_q <= '0;
    else if (src_tick) begin
      if (at_limit(pcnt_q, div_m1)) pcnt_q <= '0;
      else                          pcnt_q <= pcnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/pwm_period_core.sv
`timescale 1ns/1ps
module pwm_period_core #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          start,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] period,
  input  logic          fifo_has,
  input  logic [CW-1:0] fifo_head,
  output logic          pop,
  output logic          rollover,
  output logic [CW:0]   cnt,
  output logic [CW-1:0] cmp,
  output logic          active
);
  // last count value of a period: period register plus one
  function automatic logic [CW:0] last_count(input logic [CW-1:0] p);
    return {1'b0, p} + (CW+1)'(1);
  endfunction

  function automatic logic duty_on(input logic [CW:0] c, input logic [CW-1:0] s);
    return c < {1'b0, s};
  endfunction

  assign rollover = run && tick && !clear && (cnt >= last_count(period));
  assign pop      = (start || rollover) && fifo_has && !clear;
  assign active   = duty_on(cnt, cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      cmp <= '0;
    end else if (clear) begin
      cnt <= '0;
      cmp <= '0;
    end else begin
      if (pop) cmp <= fifo_head;
      if (start || !run || rollover) cnt <= '0;
      else if (tick)                 cnt <= cnt + (CW+1)'(1);
    end
  end
endmodule

// File: rtl/pwm_fifo_gen.sv
`timescale 1ns/1ps
module pwm_fifo_gen #(
  parameter int PRE_W      = 12,
  parameter int PER_W      = 16,
  parameter int DEPTH      = 4,
  parameter int SWR_CYCLES = 4,
  parameter int AW         = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          tick_a,
  input  logic          tick_b,
  output logic          pwm_out
);
  import pwm_pkg::*;

  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int SWC_W = $clog2(SWR_CYCLES + 1);

  // register state
  logic             en_q, inv_q, ovf_q, swr_busy;
  logic [PRE_W-1:0] div_q;
  logic [1:0]       sel_q;
  logic [2:0]       lp_q;
  logic [PER_W-1:0] period_q;
  logic [SWC_W-1:0] swr_cnt;

  // named internal events
  logic wr_ctrl, wr_stat, wr_samp, wr_per;
  logic start_ev, soft_clear, push_req, push_ok, pop_ev, rollover, wr_drop;
  logic src_tick, pre_tick, fifo_has, duty_active;
  logic [LVL_W-1:0] fifo_level;
  logic [PER_W-1:0] fifo_head, cmp_q;
  logic [PER_W:0]   cnt_q;

  logic unused_wbits;
  assign unused_wbits = &{1'b0, reg_wdata[31:25], reg_wdata[21:19]};

  assign wr_ctrl = reg_wr && !swr_busy && (reg_addr == AW'(OFF_CTRL));
  assign wr_stat = reg_wr && !swr_busy && (reg_addr == AW'(OFF_STAT));
  assign wr_samp = reg_wr && !swr_busy && (reg_addr == AW'(OFF_SAMP));
  assign wr_per  = reg_wr && !swr_busy && (reg_addr == AW'(OFF_PER));

  assign start_ev   = wr_ctrl && !reg_wdata[B_SRST] && reg_wdata[B_RUN] && !en_q;
  assign soft_clear = swr_busy && (swr_cnt == '0);
  assign push_req   = wr_samp;
  assign wr_drop    = push_req && !push_ok;

  always_comb begin
    case (src_sel_e'(sel_q))
      SRC_A:   src_tick = tick_a;
      SRC_B:   src_tick = tick_b;
      default: src_tick = 1'b0;
    endcase
  end

  pwm_prescaler #(.DIV_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n),
    .restart(start_ev || soft_clear),
    .run(en_q), .src_tick(src_tick), .div_m1(div_q), .tick(pre_tick)
  );

  pwm_sample_fifo #(.DW(PER_W), .DEPTH(DEPTH), .LW(LVL_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clear(soft_clear),
    .push(push_req), .din(reg_wdata[PER_W-1:0]), .pop(pop_ev),
    .head(fifo_head), .level(fifo_level), .has_data(fifo_has), .push_ok(push_ok)
  );

  pwm_period_core #(.CW(PER_W)) u_core (
    .clk(clk), .rst_n(rst_n), .clear(soft_clear), .start(start_ev),
    .run(en_q), .tick(pre_tick), .period(period_q),
    .fifo_has(fifo_has), .fifo_head(fifo_head),
    .pop(pop_ev), .rollover(rollover), .cnt(cnt_q), .cmp(cmp_q),
    .active(duty_active)
  );

  assign pwm_out = en_q ? (duty_active ^ inv_q) : inv_q;

  // control, period and software reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; inv_q <= 1'b0; div_q <= '0; sel_q <= '0; lp_q <= '0;
      period_q <= '0; swr_busy <= 1'b0; swr_cnt <= '0;
    end else if (soft_clear) begin
      en_q <= 1'b0; inv_q <= 1'b0; div_q <= '0; sel_q <= '0; lp_q <= '0;
      period_q <= '0; swr_busy <= 1'b0; swr_cnt <= '0;
    end else begin
      if (swr_busy) swr_cnt <= swr_cnt - SWC_W'(1);
      if (wr_ctrl) begin
        if (reg_wdata[B_SRST]) begin
          swr_busy <= 1'b1;
          swr_cnt  <= SWC_W'(SWR_CYCLES - 1);
        end else begin
          en_q  <= reg_wdata[B_RUN];
          div_q <= reg_wdata[B_DIV_LO +: PRE_W];
          sel_q <= reg_wdata[B_SRC_LO +: 2];
          inv_q <= reg_wdata[B_INV];
          lp_q  <= reg_wdata[B_LP_LO +: 3];
        end
      end
      if (wr_per) period_q <= reg_wdata[PER_W-1:0];
    end
  end

  // sticky overflow flag, set has priority over write-one-to-clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ovf_q <= 1'b0;
    else if (soft_clear)                 ovf_q <= 1'b0;
    else if (wr_drop)                    ovf_q <= 1'b1;
    else if (wr_stat && reg_wdata[B_OVF]) ovf_q <= 1'b0;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(OFF_CTRL)) begin
      reg_rdata[B_RUN]             = en_q;
      reg_rdata[B_SRST]            = swr_busy;
      reg_rdata[B_DIV_LO +: PRE_W] = div_q;
      reg_rdata[B_SRC_LO +: 2]     = sel_q;
      reg_rdata[B_INV]             = inv_q;
      reg_rdata[B_LP_LO +: 3]      = lp_q;
    end else if (reg_addr == AW'(OFF_STAT)) begin
      reg_rdata[LVL_W-1:0] = fifo_level;
      reg_rdata[B_OVF]     = ovf_q;
    end else if (reg_addr == AW'(OFF_SAMP)) begin
      reg_rdata[PER_W-1:0] = cmp_q;
    end else if (reg_addr == AW'(OFF_PER)) begin
      reg_rdata[PER_W-1:0] = period_q;
    end
  end
endmodule

// File: rtl/pwm_fifo_gen_chk.sv
`timescale 1ns/1ps
module pwm_fifo_gen_chk #(
  parameter int DEPTH = 4,
  parameter int LVL_W = 3,
  parameter int PER_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_q,
  input logic             inv_q,
  input logic             pwm_out,
  input logic [LVL_W-1:0] fifo_level,
  input logic             push_req,
  input logic             push_ok,
  input logic             pop_ev,
  input logic             wr_drop,
  input logic             rollover,
  input logic             soft_clear,
  input logic             swr_busy,
  input logic             ovf_q,
  input logic [PER_W:0]   cnt_q
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  assert_level_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= FULL_LVL);

  assert_drop_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |=> (ovf_q && fifo_level == FULL_LVL));

  assert_rollover_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rollover |=> (cnt_q == '0));

  assert_pop_drains_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ev && !push_ok && !soft_clear) |=> (fifo_level == $past(fifo_level) - LVL_W'(1)));

  assert_idle_counter_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && $past(!en_q)) |-> (cnt_q == '0));

  assert_idle_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && $past(!en_q) && $stable(inv_q)) |-> $stable(pwm_out));

  assert_srst_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clear |=> (fifo_level == '0 && cnt_q == '0 && !swr_busy && !en_q && !ovf_q));

  assert_srst_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(swr_busy) |-> $past(soft_clear));

  assert_full_swap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level == FULL_LVL && pop_ev && push_req && !soft_clear)
      |=> (fifo_level == FULL_LVL && !$rose(ovf_q)));
endmodule

bind pwm_fifo_gen pwm_fifo_gen_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W), .PER_W(PER_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .inv_q(inv_q), .pwm_out(pwm_out),
  .fifo_level(fifo_level), .push_req(push_req), .push_ok(push_ok),
  .pop_ev(pop_ev), .wr_drop(wr_drop), .rollover(rollover),
  .soft_clear(soft_clear), .swr_busy(swr_busy), .ovf_q(ovf_q), .cnt_q(cnt_q)
);

// File: tb/sim_pwm_fifo_gen.sv
`timescale 1ns/1ps
module sim_pwm_fifo_gen;
  localparam int A_CTRL = 'h00, A_STAT = 'h04, A_SAMP = 'h0C, A_PER = 'h10;
  localparam int NVEC = 6;
  // divide field, period, first sample, second sample
  localparam int VEC [NVEC][4] = '{
    '{0, 6, 3, 5}, '{1, 4, 0, 6}, '{2, 10, 12, 1},
    '{0, 0, 1, 2}, '{3, 3, 2, 9}, '{0, 20, 7, 21}
  };

  logic clk = 0, rst_n = 0, reg_wr = 0, tick_a = 1, tick_b = 0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        pwm_out;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  pwm_fifo_gen u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tick_a(tick_a), .tick_b(tick_b), .pwm_out(pwm_out)
  );

  always #4 clk = ~clk;

  function automatic int exp_period(input int n, input int p);
    return (p + 2) * (n + 1);
  endfunction
  function automatic int exp_high(input int n, input int p, input int s);
    int t = (s < p + 2) ? s : p + 2;
    return t * (n + 1);
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    reg_wr = 1; reg_addr = addr[4:0]; reg_wdata = data;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic rd(input int addr, output int data);
    @(negedge clk);
    reg_addr = addr[4:0];
    #1 data = reg_rdata;
  endtask

  task automatic measure(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int v, h1, h2, cyc;
    repeat (3) @(posedge clk);
    rst_n = 1;

    // R1 reset values
    rd(A_CTRL, v); chk(v, 0, "R1 ctrl reset");
    rd(A_STAT, v); chk(v, 0, "R1 status reset");
    rd(A_SAMP, v); chk(v, 0, "R1 sample reset");
    rd(A_PER, v);  chk(v, 0, "R1 period reset");
    chk(pwm_out, 0, "R8 output at reset");

    // R1 field layout, enable left off
    wr(A_CTRL, 32'h01C6_ABC0);
    rd(A_CTRL, v); chk(v, 32'h01C6_ABC0, "R1 ctrl readback");
    wr(A_PER, 32'h0005_1234);
    rd(A_PER, v); chk(v, 32'h1234, "R1 period width");
    chk(pwm_out, 1, "R8 idle level with inversion");
    wr(A_CTRL, 0);

    // R2 R3 R11 table walk
    for (int k = 0; k < NVEC; k++) begin
      wr(A_CTRL, 0);
      wr(A_PER, VEC[k][1]);
      wr(A_SAMP, VEC[k][2]);
      wr(A_SAMP, VEC[k][3]);
      wr(A_CTRL, (1 << 16) | (VEC[k][0] << 4) | 1);
      measure(exp_period(VEC[k][0], VEC[k][1]), h1);
      measure(exp_period(VEC[k][0], VEC[k][1]), h2);
      chk(h1, exp_high(VEC[k][0], VEC[k][1], VEC[k][2]), "R11 R3 first period high time");
      chk(h2, exp_high(VEC[k][0], VEC[k][1], VEC[k][3]), "R2 R3 second period high time");
    end
    wr(A_CTRL, 0);

    // R5 R6 level and overflow
    rd(A_STAT, v); chk(v, 0, "R5 empty level");
    wr(A_SAMP, 3); rd(A_STAT, v); chk(v, 1, "R5 level 1");
    wr(A_SAMP, 1); wr(A_SAMP, 2); rd(A_STAT, v); chk(v, 3, "R5 level 3");
    wr(A_SAMP, 0); rd(A_STAT, v); chk(v, 4, "R5 full level");
    wr(A_SAMP, 4); rd(A_STAT, v); chk(v, 'h14, "R6 drop sets flag");
    wr(A_STAT, 'h10); rd(A_STAT, v); chk(v, 4, "R6 write one clears flag");
    // R4 order 3,1,2,0 then held; the dropped 4 must not appear
    wr(A_PER, 2);
    wr(A_CTRL, 'h10001);
    measure(4, h1); chk(h1, 3, "R4 window 1");
    measure(4, h1); chk(h1, 1, "R4 window 2");
    measure(4, h1); chk(h1, 2, "R4 window 3");
    measure(4, h1); chk(h1, 0, "R4 window 4");
    measure(4, h1); chk(h1, 0, "R4 R6 empty queue keeps value");
    wr(A_CTRL, 0);

    // R7 inversion: period 6, sample 2
    wr(A_PER, 4); wr(A_SAMP, 2);
    wr(A_CTRL, 'h50001);
    measure(6, h1); chk(h1, 4, "R7 inverted high time");
    wr(A_CTRL, 'h40000);
    measure(10, h1); chk(h1, 10, "R8 idle inverted level");
    wr(A_CTRL, 0);
    measure(10, h1); chk(h1, 0, "R8 idle plain level");

    // R10 clock source select
    tick_a = 0; tick_b = 1;
    wr(A_PER, 2); wr(A_SAMP, 2);
    wr(A_CTRL, 'h20001);
    measure(4, h1); chk(h1, 2, "R10 source b period 1");
    measure(4, h1); chk(h1, 2, "R10 source b period 2");
    wr(A_CTRL, 0); wr(A_SAMP, 1);
    wr(A_CTRL, 'h10001);
    measure(10, h1); chk(h1, 10, "R10 idle source stalls counter");
    wr(A_CTRL, 0);
    tick_a = 1; tick_b = 0;

    // R12 push on a rollover edge while full
    wr(A_SAMP, 1); wr(A_SAMP, 1); wr(A_SAMP, 1); wr(A_SAMP, 1);
    wr(A_CTRL, 'h10001);          // edge E, pop leaves 3
    wr(A_SAMP, 1);                // edge E+1, full again
    repeat (2) @(negedge clk);
    wr(A_SAMP, 1);                // edge E+4, rollover
    rd(A_STAT, v); chk(v, 4, "R12 push accepted on rollover");

    // R9 software reset
    wr(A_CTRL, 'h8);
    cyc = 0;
    for (int i = 0; i < 20; i++) begin
      rd(A_CTRL, v);
      if (v[3] == 0) break;
      cyc++;
    end
    chk(cyc >= 1, 1, "R9 reset bit reads set");
    chk(cyc <= 8, 1, "R9 reset completes");
    rd(A_CTRL, v); chk(v, 0, "R9 ctrl cleared");
    rd(A_STAT, v); chk(v, 0, "R9 status cleared");
    rd(A_PER, v);  chk(v, 0, "R9 period cleared");
    rd(A_SAMP, v); chk(v, 0, "R9 compare cleared");
    chk(pwm_out, 0, "R9 output cleared");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule